// File: doc/BRIEF.md
# Processor Status Word Register

This block holds the 32-bit status word of a processor and updates it once per executed operation. It sits behind the ALU. For each operation it takes the two operands, the result, the carry/borrow out and an operation class. From these it derives the six arithmetic status flags for an 8, 16 or 32-bit operation and writes each one into its fixed bit position. Explicit set/clear operations for the interrupt-enable and direction bits, and a full-word load, share the same port.

The block does not interpret the upper control bits: privilege level, nested task, resume, virtual mode, alignment check, virtual interrupt, virtual interrupt pending and identification. It only stores them and reads them back. Data-transfer and control operations leave the word untouched. Reserved positions always read as constants.

Top module: `status_word_reg`

## Requirements
- R1: While reset is held low the status word reads 0x00000002.
- R2: An add (class 1) or subtract (class 2) writes `alu_carry` to bit 0. Bit 6 is set when the size-masked result is zero. Bit 7 receives the sign bit of the result at the operand size.
- R3: After class 1, 2 or 3, bit 2 is 1 when result bits 7..0 contain an even number of ones and 0 when the count is odd, whatever the operand size.
- R4: After an add or subtract, bit 4 equals the carry or borrow from bit 3 into bit 4, computed as a[4]^b[4]^result[4].
- R5: Bit 11 is set on an add when both operands share a sign that differs from the result's sign. On a subtract (a minus b) it is set when the operand signs differ and the result's sign differs from a's.
- R6: A logic operation (class 3) clears bits 0, 4 and 11.
- R7: The word is unchanged after a data-transfer/control operation (class 0), after any class code from 9 to 15, and in any cycle with `op_valid` low.
- R8: Class 4 sets bit 9 and class 5 clears it. Class 6 sets bit 10 and class 7 clears it. No other bit changes.
- R9: Operations of class 1, 2 and 3 leave bits 8, 9, 10 and 12 to 21 unchanged.
- R10: A load (class 8) copies `load_word` into bits 0, 2, 4, 6 to 14 and 16 to 21. At all times bit 1 reads 1, and bits 3, 5, 15 and 22 to 31 read 0.
- R11: `op_size` 0 selects a byte (sign at bit 7), 1 a half word (sign at bit 15), and 2 or 3 a word (sign at bit 31). Result bits above the size do not affect the zero flag.
- R12: Every update takes effect at the rising clock edge that samples `op_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation completes in this cycle |
| op_class | input | 4 | 0 transfer/control, 1 add, 2 subtract, 3 logic, 4 set IE, 5 clear IE, 6 set direction, 7 clear direction, 8 load, 9-15 no effect |
| op_size | input | 2 | 0 byte, 1 half word, 2/3 word |
| opnd_a | input | 32 | First ALU operand (minuend on subtract) |
| opnd_b | input | 32 | Second ALU operand |
| alu_result | input | 32 | ALU result, upper bits above the size ignored |
| alu_carry | input | 1 | Carry out (add) or borrow out (subtract) at the operand size |
| load_word | input | 32 | Value for a full-word load |
| status_word | output | 32 | Current status word |

## Verification
The assertions take for granted that `op_class` and `op_size` are never X once reset is released. They also assume that `alu_carry` is already the carry or borrow at the selected size, because the block does not recompute it. The stimulus drives only defined class codes, plus one out-of-range code, and pairs each operand set with a result and carry that an ALU of that size would produce. Upper result bits are deliberately filled with noise on byte and half-word operations, to show that they are ignored.

// File: rtl/psw_pkg.sv
package psw_pkg;

   typedef enum logic [3:0] {
      OPC_MOVE    = 4'd0,
      OPC_ADD     = 4'd1,
      OPC_SUB     = 4'd2,
      OPC_LOGIC   = 4'd3,
      OPC_SET_IE  = 4'd4,
      OPC_CLR_IE  = 4'd5,
      OPC_SET_DIR = 4'd6,
      OPC_CLR_DIR = 4'd7,
      OPC_LOAD    = 4'd8
   } op_class_e;

   // fixed flag positions inside the status word
   localparam int unsigned POS_CF  = 0;
   localparam int unsigned POS_PF  = 2;
   localparam int unsigned POS_AF  = 4;
   localparam int unsigned POS_ZF  = 6;
   localparam int unsigned POS_SF  = 7;
   localparam int unsigned POS_TF  = 8;
   localparam int unsigned POS_IE  = 9;
   localparam int unsigned POS_DIR = 10;
   localparam int unsigned POS_OF  = 11;
   localparam int unsigned POS_CTL_LO = 12;
   localparam int unsigned POS_CTL_HI = 21;

   // operand bit whose carry-in is the nibble (auxiliary) carry
   localparam int unsigned NIBBLE_W = 4;

   typedef struct packed {
      logic cf;
      logic pf;
      logic af;
      logic zf;
      logic sf;
      logic of;
   } arith_flags_t;

   function automatic logic is_flag_op(op_class_e c);
      return (c == OPC_ADD) || (c == OPC_SUB) || (c == OPC_LOGIC);
   endfunction

endpackage

// File: rtl/psw_parity.sv
module psw_parity #(
   parameter int unsigned W     = 8,
   parameter bit          CHAIN = 1'b0
) (
   input  logic [W-1:0] d,
   output logic         even
);

   if (W < 1) begin : g_bad_w
      $error("psw_parity: W must be at least 1");
   end

   if (CHAIN) begin : g_chain
      logic odd_acc;
      always_comb begin
         odd_acc = 1'b0;
         for (int i = 0; i < W; i++) begin
            odd_acc = odd_acc ^ d[i];
         end
      end
      assign even = ~odd_acc;
   end else begin : g_reduce
      assign even = ~^d;
   end

endmodule

// File: rtl/psw_size_view.sv
module psw_size_view #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LANES  = 3,
   parameter int unsigned LANE0_W = 8
) (
   input  logic [1:0]        size,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic [WORD_W-1:0] r,
   output logic              a_top,
   output logic              b_top,
   output logic              r_top,
   output logic              r_zero
);

   localparam int unsigned WIDEST = LANE0_W << (LANES - 1);
   localparam logic [1:0]  LAST   = 2'(LANES - 1);

   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("psw_size_view: LANES must be 1..4");
   end
   if (WIDEST > WORD_W) begin : g_bad_word
      $error("psw_size_view: widest lane exceeds WORD_W");
   end

   logic [LANES-1:0] a_msb, b_msb, r_msb, r_nz;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int unsigned LW = LANE0_W << k;
      assign a_msb[k] = a[LW-1];
      assign b_msb[k] = b[LW-1];
      assign r_msb[k] = r[LW-1];
      assign r_nz[k]  = |r[LW-1:0];
   end

   logic [1:0] lane_sel;
   assign lane_sel = (size > LAST) ? LAST : size;

   assign a_top  = a_msb[lane_sel];
   assign b_top  = b_msb[lane_sel];
   assign r_top  = r_msb[lane_sel];
   assign r_zero = ~r_nz[lane_sel];

   logic unused_bits;
   assign unused_bits = ^{a, b, r};

endmodule

// File: rtl/psw_arith_flags.sv
module psw_arith_flags
   import psw_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned PAR_W     = 8,
   parameter bit          PAR_CHAIN = 1'b0
) (
   input  op_class_e         cls,
   input  logic [1:0]        size,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  logic [WORD_W-1:0] r,
   input  logic              carry,
   output arith_flags_t      flags
);

   if (PAR_W > WORD_W || NIBBLE_W >= WORD_W) begin : g_bad_cfg
      $error("psw_arith_flags: PAR_W or NIBBLE_W out of range");
   end

   logic a_top, b_top, r_top, r_zero, par_even, nib_carry;

   psw_size_view #(
      .WORD_W (WORD_W)
   ) u_view (
      .size   (size),
      .a      (a),
      .b      (b),
      .r      (r),
      .a_top  (a_top),
      .b_top  (b_top),
      .r_top  (r_top),
      .r_zero (r_zero)
   );

   psw_parity #(
      .W     (PAR_W),
      .CHAIN (PAR_CHAIN)
   ) u_par (
      .d    (r[PAR_W-1:0]),
      .even (par_even)
   );

   // carry into bit NIBBLE_W is the same sum bit for add and subtract
   assign nib_carry = a[NIBBLE_W] ^ b[NIBBLE_W] ^ r[NIBBLE_W];

   always_comb begin
      flags    = '0;
      flags.pf = par_even;
      flags.zf = r_zero;
      flags.sf = r_top;
      unique case (cls)
         OPC_ADD: begin
            flags.cf = carry;
            flags.af = nib_carry;
            flags.of = (a_top == b_top) && (r_top != a_top);
         end
         OPC_SUB: begin
            flags.cf = carry;
            flags.af = nib_carry;
            flags.of = (a_top != b_top) && (r_top != a_top);
         end
         default: begin
            flags.cf = 1'b0;
            flags.af = 1'b0;
            flags.of = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/psw_store.sv
module psw_store
   import psw_pkg::*;
#(
   parameter int unsigned        WORD_W     = 32,
   parameter logic [WORD_W-1:0]  WRITE_MASK = 'h003F_7FD5,
   parameter logic [WORD_W-1:0]  FIXED_VAL  = 'h0000_0002,
   parameter logic [WORD_W-1:0]  RESET_VAL  = 'h0000_0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  op_class_e         cls,
   input  arith_flags_t      flags,
   input  logic [WORD_W-1:0] load_word,
   output logic [WORD_W-1:0] word
);

   if ((FIXED_VAL & WRITE_MASK) != '0) begin : g_bad_fixed
      $error("psw_store: FIXED_VAL overlaps writable bits");
   end
   if ((RESET_VAL & ~WRITE_MASK) != FIXED_VAL) begin : g_bad_reset
      $error("psw_store: RESET_VAL disagrees with FIXED_VAL");
   end
   if (!WRITE_MASK[POS_CF] || !WRITE_MASK[POS_PF] || !WRITE_MASK[POS_AF] ||
       !WRITE_MASK[POS_ZF] || !WRITE_MASK[POS_SF] || !WRITE_MASK[POS_IE] ||
       !WRITE_MASK[POS_DIR] || !WRITE_MASK[POS_OF]) begin : g_bad_mask
      $error("psw_store: a flag position is not writable");
   end

   logic [WORD_W-1:0] nxt_raw, nxt;

   always_comb begin
      nxt_raw = word;
      if (op_valid) begin
         unique case (cls)
            OPC_ADD, OPC_SUB, OPC_LOGIC: begin
               nxt_raw[POS_CF] = flags.cf;
               nxt_raw[POS_PF] = flags.pf;
               nxt_raw[POS_AF] = flags.af;
               nxt_raw[POS_ZF] = flags.zf;
               nxt_raw[POS_SF] = flags.sf;
               nxt_raw[POS_OF] = flags.of;
            end
            OPC_SET_IE:  nxt_raw[POS_IE]  = 1'b1;
            OPC_CLR_IE:  nxt_raw[POS_IE]  = 1'b0;
            OPC_SET_DIR: nxt_raw[POS_DIR] = 1'b1;
            OPC_CLR_DIR: nxt_raw[POS_DIR] = 1'b0;
            OPC_LOAD:    nxt_raw          = load_word;
            default:     nxt_raw          = word;
         endcase
      end
      nxt = (nxt_raw & WRITE_MASK) | FIXED_VAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word <= RESET_VAL;
      else        word <= nxt;
   end

   // R10: reserved positions never move
   assert_reserved_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (word & ~WRITE_MASK) == FIXED_VAL);

   // R7: transfer/control and idle cycles keep the word
   assert_transfer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid || cls == OPC_MOVE) |=> $stable(word));

   // R8: set interrupt enable touches bit 9 only
   assert_set_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cls == OPC_SET_IE) |=> (word[POS_IE] && $stable(word[POS_IE-1:0])));

   // R8: clear direction
   assert_clr_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cls == OPC_CLR_DIR) |=> (!word[POS_DIR] && $stable(word[POS_IE:0])));

   // R6: logic clears carry, auxiliary carry and overflow
   assert_logic_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cls == OPC_LOGIC) |=> (!word[POS_CF] && !word[POS_AF] && !word[POS_OF]));

   // R9: flag operations keep control bits
   assert_ctl_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_flag_op(cls)) |=>
         ($stable(word[POS_DIR:POS_TF]) && $stable(word[POS_CTL_HI:POS_CTL_LO])));

endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
   import psw_pkg::*;
#(
   parameter int unsigned       WORD_W     = 32,
   parameter int unsigned       PAR_W      = 8,
   parameter bit                PAR_CHAIN  = 1'b0,
   parameter logic [WORD_W-1:0] WRITE_MASK = 'h003F_7FD5,
   parameter logic [WORD_W-1:0] FIXED_VAL  = 'h0000_0002,
   parameter logic [WORD_W-1:0] RESET_VAL  = 'h0000_0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_class,
   input  logic [1:0]        op_size,
   input  logic [WORD_W-1:0] opnd_a,
   input  logic [WORD_W-1:0] opnd_b,
   input  logic [WORD_W-1:0] alu_result,
   input  logic              alu_carry,
   input  logic [WORD_W-1:0] load_word,
   output logic [WORD_W-1:0] status_word
);

   if (WORD_W < POS_CTL_HI + 1) begin : g_bad_word
      $error("status_word_reg: WORD_W too small for the flag layout");
   end

   op_class_e    cls;
   arith_flags_t flags;

   assign cls = op_class_e'(op_class);

   psw_arith_flags #(
      .WORD_W    (WORD_W),
      .PAR_W     (PAR_W),
      .PAR_CHAIN (PAR_CHAIN)
   ) u_flags (
      .cls   (cls),
      .size  (op_size),
      .a     (opnd_a),
      .b     (opnd_b),
      .r     (alu_result),
      .carry (alu_carry),
      .flags (flags)
   );

   psw_store #(
      .WORD_W     (WORD_W),
      .WRITE_MASK (WRITE_MASK),
      .FIXED_VAL  (FIXED_VAL),
      .RESET_VAL  (RESET_VAL)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .cls       (cls),
      .flags     (flags),
      .load_word (load_word),
      .word      (status_word)
   );

   // R11: a zero byte result sets bit 6 whatever the upper bits hold
   assert_byte_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_class == 4'd1 && op_size == 2'd0 && alu_result[7:0] == 8'h00)
         |=> status_word[POS_ZF]);

   // R2: the carry input lands in bit 0 on an add
   assert_add_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_class == 4'd1) |=> (status_word[POS_CF] == $past(alu_carry)));

endmodule

// File: tb/sim_status_word_reg.sv
module sim_status_word_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_class = 4'd0;
   logic [1:0]  op_size = 2'd0;
   logic [31:0] opnd_a = '0, opnd_b = '0, alu_result = '0, load_word = '0;
   logic        alu_carry = 1'b0;
   logic [31:0] status_word;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] exp_cur = 32'h0000_0002;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   status_word_reg u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_valid    (op_valid),
      .op_class    (op_class),
      .op_size     (op_size),
      .opnd_a      (opnd_a),
      .opnd_b      (opnd_b),
      .alu_result  (alu_result),
      .alu_carry   (alu_carry),
      .load_word   (load_word),
      .status_word (status_word)
   );

   function automatic logic [31:0] model(logic [31:0] cur, logic v, logic [3:0] c,
                                         logic [1:0] sz, logic [31:0] a, logic [31:0] b,
                                         logic [31:0] r, logic cy, logic [31:0] ld);
      logic [31:0] n, m;
      int          top;
      logic        as, bs, rs;
      n = cur;
      if (!v) return n;
      top = (sz == 2'd0) ? 7 : (sz == 2'd1) ? 15 : 31;
      m   = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
      as = a[top]; bs = b[top]; rs = r[top];
      case (c)
         4'd1, 4'd2, 4'd3: begin
            n[0]  = (c == 4'd3) ? 1'b0 : cy;
            n[2]  = ~^r[7:0];
            n[4]  = (c == 4'd3) ? 1'b0 : (a[4] ^ b[4] ^ r[4]);
            n[6]  = ((r & m) == 32'h0);
            n[7]  = rs;
            n[11] = (c == 4'd1) ? (as == bs && rs != as) :
                    (c == 4'd2) ? (as != bs && rs != as) : 1'b0;
         end
         4'd4: n[9]  = 1'b1;
         4'd5: n[9]  = 1'b0;
         4'd6: n[10] = 1'b1;
         4'd7: n[10] = 1'b0;
         4'd8: n = (ld & 32'h003F_7FD5) | 32'h0000_0002;
         default: ;
      endcase
      return n;
   endfunction

   // driver: one operation per cycle, expected word pushed to the scoreboard
   task automatic apply(logic v, logic [3:0] c, logic [1:0] sz, logic [31:0] a,
                        logic [31:0] b, logic [31:0] r, logic cy, logic [31:0] ld,
                        string tag);
      @(negedge clk);
      op_valid = v; op_class = c; op_size = sz;
      opnd_a = a; opnd_b = b; alu_result = r; alu_carry = cy; load_word = ld;
      exp_cur = model(exp_cur, v, c, sz, a, b, r, cy, ld);
      exp_q.push_back(exp_cur);
      tag_q.push_back(tag);
   endtask

   // monitor: the word settles one edge after the operation is sampled (R12)
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (status_word !== e) begin
               n_fail++;
               $display("FAIL %s: got %08h expected %08h", t, status_word, e);
            end
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      n_tests++;
      if (status_word !== 32'h0000_0002) begin
         n_fail++;
         $display("FAIL R1 reset: got %08h expected %08h", status_word, 32'h2);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R5 R2 byte add with signed overflow
      apply(1, 4'd1, 2'd0, 32'h7F, 32'h01, 32'h80, 1'b0, '0, "R5 add ovf byte");
      // R11 R2 byte zero with noisy upper bits, carry out
      apply(1, 4'd1, 2'd0, 32'hFF, 32'h01, 32'hABCD_1200, 1'b1, '0, "R11 byte zero");
      // R4 nibble carry
      apply(1, 4'd1, 2'd0, 32'h08, 32'h08, 32'h10, 1'b0, '0, "R4 aux carry");
      // R11 half-word subtract with borrow, sign at bit 15
      apply(1, 4'd2, 2'd1, 32'h5555_0000, 32'h0001, 32'h0000_FFFF, 1'b1, '0, "R11 half sub");
      // R5 word subtract overflow
      apply(1, 4'd2, 2'd2, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 1'b0, '0, "R5 sub ovf word");
      // R3 parity over low byte only
      apply(1, 4'd1, 2'd2, 32'h0000_FF00, 32'h1, 32'h0000_FF01, 1'b0, '0, "R3 parity low byte");
      // R6 logic with carry input set
      apply(1, 4'd3, 2'd2, 32'h0, 32'h0, 32'h0000_00F0, 1'b1, '0, "R6 logic clears");
      // R11 size 3 acts as word
      apply(1, 4'd1, 2'd3, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1'b0, '0, "R11 size3 word");
      // R7 transfer, idle and unused class
      apply(1, 4'd0, 2'd0, 32'h0, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, "R7 transfer");
      apply(0, 4'd1, 2'd0, 32'hFF, 32'h1, 32'h0, 1'b1, '0, "R7 valid low");
      apply(1, 4'd15, 2'd0, 32'h0, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, "R7 unused code");
      // R8 set/clear interrupt enable and direction
      apply(1, 4'd4, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, '0, "R8 set ie");
      apply(1, 4'd6, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, '0, "R8 set dir");
      apply(1, 4'd5, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, '0, "R8 clr ie");
      apply(1, 4'd7, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, '0, "R8 clr dir");
      // R10 load all ones, reserved bits stay fixed
      apply(1, 4'd8, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 32'hFFFF_FFFF, "R10 load ones");
      // R9 arithmetic keeps control bits after the load
      apply(1, 4'd2, 2'd0, 32'h10, 32'h20, 32'hF0, 1'b1, '0, "R9 sub keeps ctl");
      apply(1, 4'd3, 2'd1, 32'h0, 32'h0, 32'h0001_0000, 1'b0, '0, "R9 logic keeps ctl");
      // R10 load zero
      apply(1, 4'd8, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 32'h0, "R10 load zero");
      apply(0, 4'd0, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, '0, "R12 idle");

      wait (exp_q.size() == 0);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule